// File: doc/BRIEF.md
# Hard-Decision Viterbi Decoder, Rate 1/2, Four States

This block decodes a stream protected by the rate-1/2 convolutional code whose encoder keeps the two previous message bits. For each message bit the encoder sends two bits: the first is the current bit XOR both stored bits, and the second is the current bit XOR the older stored bit. The decoder accepts one hard-decision two-bit symbol per valid strobe. For each of the four trellis states it adds a Hamming branch metric to the metric of each predecessor, keeps the smaller sum, and records which predecessor survived.

Survivor decisions are kept for the last sixteen symbols. Once sixteen symbols have arrived, every accepted symbol gives one decoded bit. The decoder finds the state with the lowest path metric and follows its survivor path back fifteen steps. The output bit is the message bit that was sent fifteen symbols before the newest one. Path metrics are renormalised on every step so that their width stays small. The traceback is combinational from registered state, so the decoder accepts a new symbol on every clock cycle.

Top module: `viterbi_k3_hard`

## Requirements
- R1: While reset is asserted, and for the first 15 symbols accepted after reset, `dec_valid` stays low.
- R2: `sym_in[1]` holds the first encoder output (current bit XOR both stored bits) and `sym_in[0]` holds the second (current bit XOR the older stored bit). For an error-free stream, the bit shown with the Nth accepted symbol (N counted from 1, N ≥ 16) equals message bit N−15.
- R3: From the 16th symbol onward, `dec_valid` is high for exactly the one cycle after each accepted symbol, and it is low in every cycle that follows an idle cycle.
- R4: Single-bit symbol errors spaced at least 20 symbols apart are fully corrected in the decoded output.
- R5: Path metrics never overflow. After every step the smallest metric is zero and every metric stays at or below the initial penalty plus four. Correct decoding therefore holds over streams of any length.
- R6: The decoder assumes the encoder starts in state 00. Only that state begins with metric zero, and the other states begin with a large penalty. A stream of all-zero messages whose first symbol is received as 01 decodes to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | A symbol is present on `sym_in` this cycle |
| sym_in | input | 2 | Received hard-decision symbol, first code bit in bit 1 |
| dec_valid | output | 1 | A decoded bit is present on `dec_bit` |
| dec_bit | output | 1 | Decoded message bit, 15 symbols behind the input |

## Verification
On every cycle, the assertions check the metric bound and that the renormalised minimum is zero. They also check that no output appears before sixteen symbols or without a symbol in the previous cycle, and that every later symbol produces exactly one output. Only the bench scenarios can show that the decoded bits are correct. These scenarios are an error-free stream covering every 8-bit message pattern, a stream with isolated injected errors, traffic with idle gaps, an ambiguous first symbol that exercises the start-state assumption, and a restart after reset in the middle of a stream.

// File: rtl/viterbi_k3_hard.sv
module viterbi_k3_hard #(
  parameter int MW = 4,
  parameter int DELAY = 15,
  parameter logic [MW-1:0] INIT_PEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_valid,
  input  logic [1:0] sym_in,
  output logic       dec_valid,
  output logic       dec_bit
);
  localparam int DEPTH = DELAY + 1;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [MW-1:0] pm [4];
  logic [3:0]    surv [DEPTH];
  logic [PW-1:0] wptr;
  logic [CW-1:0] seen;
  logic          fresh;

  logic [MW-1:0] nxt [4];
  logic [MW-1:0] nmin;
  logic [3:0]    pick;
  logic [1:0]    best;
  logic [1:0]    trace;

  function automatic logic [MW-1:0] ham(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] x;
    x = a ^ b;
    return MW'(x[1]) + MW'(x[0]);
  endfunction

  // add-compare-select: state index {m2,m1}, next {m1,u}, predecessor {m2,m1}
  always_comb begin
    for (int n = 0; n < 4; n++) begin
      logic [1:0] ns;
      logic [MW-1:0] lo, hi;
      ns = 2'(n);
      lo = pm[{1'b0, ns[1]}] + ham(sym_in, {ns[0] ^ ns[1], ns[0]});
      hi = pm[{1'b1, ns[1]}] + ham(sym_in, {~(ns[0] ^ ns[1]), ~ns[0]});
      pick[n] = hi < lo;
      nxt[n]  = pick[n] ? hi : lo;
    end
    nmin = nxt[0];
    for (int n = 1; n < 4; n++)
      if (nxt[n] < nmin) nmin = nxt[n];
  end

  // winner: lowest metric, lowest index on a tie; then trace back DELAY steps
  always_comb begin
    logic [MW-1:0] m;
    logic [PW-1:0] ix;
    m = pm[0];
    for (int n = 1; n < 4; n++)
      if (pm[n] < m) m = pm[n];
    best = 2'd0;
    for (int n = 3; n >= 0; n--)
      if (pm[n] == m) best = 2'(n);
    trace = best;
    ix = (wptr == '0) ? PW'(DEPTH - 1) : wptr - 1'b1;
    for (int j = 0; j < DELAY; j++) begin
      trace = {surv[ix][trace], trace[1]};
      ix = (ix == '0) ? PW'(DEPTH - 1) : ix - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pm[0] <= '0;
      for (int n = 1; n < 4; n++) pm[n] <= INIT_PEN;
      for (int d = 0; d < DEPTH; d++) surv[d] <= '0;
      wptr  <= '0;
      seen  <= '0;
      fresh <= 1'b0;
    end else begin
      fresh <= sym_valid;
      if (sym_valid) begin
        for (int n = 0; n < 4; n++) pm[n] <= nxt[n] - nmin;
        surv[wptr] <= pick;
        wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        if (seen != CW'(DEPTH)) seen <= seen + 1'b1;
      end
    end
  end

  assign dec_valid = fresh && (seen == CW'(DEPTH));
  assign dec_bit   = trace[0];
endmodule

// File: rtl/viterbi_k3_hard_chk.sv
module viterbi_k3_hard_chk #(
  parameter int MW = 4,
  parameter int DELAY = 15,
  parameter logic [MW-1:0] INIT_PEN = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sym_valid,
  input logic          dec_valid,
  input logic [MW-1:0] pm [4]
);
  localparam int DEPTH = DELAY + 1;
  localparam int BOUND = int'(INIT_PEN) + 4;

  int cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= 0;
    else if (sym_valid && cnt < DEPTH) cnt <= cnt + 1;
  end

  AST_QUIET_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> cnt >= DEPTH); // R1
  AST_OUT_HAS_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(sym_valid)); // R3
  AST_ONE_PER_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && cnt >= DEPTH - 1) |=> dec_valid); // R3
  AST_METRIC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pm[0]) <= BOUND && int'(pm[1]) <= BOUND &&
    int'(pm[2]) <= BOUND && int'(pm[3]) <= BOUND); // R5
  AST_MIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pm[0] == '0 || pm[1] == '0 || pm[2] == '0 || pm[3] == '0); // R5
endmodule

bind viterbi_k3_hard viterbi_k3_hard_chk #(.MW(MW), .DELAY(DELAY), .INIT_PEN(INIT_PEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .dec_valid(dec_valid), .pm(pm)
);

// File: tb/tb_viterbi_k3_hard.sv
module tb_viterbi_k3_hard;
  localparam int CLK_PERIOD = 10;
  localparam int LAG = 15;
  localparam int NMAX = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_valid = 1'b0;
  logic [1:0] sym_in = 2'b00;
  logic dec_valid, dec_bit;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic msg [NMAX];
  logic s1, s2;

  always #(CLK_PERIOD/2) clk = ~clk;

  viterbi_k3_hard dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_in(sym_in),
    .dec_valid(dec_valid), .dec_bit(dec_bit)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sym_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(dec_valid == 1'b0, "R1 reset", int'(dec_valid), 0);
    rst_n = 1'b1;
    s1 = 1'b0;
    s2 = 1'b0;
  endtask

  // entered at a falling edge; returns at the next falling edge
  task automatic send(input logic [1:0] sym);
    sym_in = sym;
    sym_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
    check(dec_valid == 1'b0, "R3 idle", int'(dec_valid), 0);
  endtask

  function automatic logic [1:0] encode(input logic u);
    logic [1:0] c;
    c = {u ^ s1 ^ s2, u ^ s2};
    s2 = s1;
    s1 = u;
    return c;
  endfunction

  task automatic check_out(input int k, input string req);
    if (k < LAG) begin
      check(dec_valid == 1'b0, "R1 early", int'(dec_valid), 0);
    end else begin
      check(dec_valid == 1'b1, "R3 valid", int'(dec_valid), 1);
      check(dec_bit == msg[k - LAG], req, int'(dec_bit), int'(msg[k - LAG]));
    end
  endtask

  task automatic run(input int len, input int err_gap, input bit gaps, input string req);
    do_reset();
    for (int k = 0; k < len; k++) begin
      logic [1:0] c;
      c = encode(msg[k]);
      if (err_gap > 0 && (k % err_gap) == err_gap / 2)
        c = c ^ (((k / err_gap) % 2 == 0) ? 2'b10 : 2'b01);
      send(c);
      check_out(k, req);
      if (gaps && (k % 3 == 0)) idle();
    end
  endtask

  initial begin
    s1 = 1'b0;
    s2 = 1'b0;
    @(negedge clk);
    check(dec_valid == 1'b0, "R1 reset", int'(dec_valid), 0);

    // R2/R5: every 8-bit pattern back to back, error-free
    for (int k = 0; k < NMAX; k++) msg[k] = 1'((k / 8) >> (7 - (k % 8)));
    run(NMAX, 0, 1'b0, "R2 R5 error-free");

    // R4: pseudo-random message with isolated errors every 20 symbols
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int k = 0; k < NMAX; k++) begin
        msg[k] = lf[0];
        lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
      end
    end
    run(NMAX, 20, 1'b0, "R4 corrected");

    // R3: idle gaps between symbols
    run(200, 0, 1'b1, "R3 gapped");

    // R6: all-zero message, first symbol received as 01
    for (int k = 0; k < 40; k++) msg[k] = 1'b0;
    do_reset();
    for (int k = 0; k < 40; k++) begin
      logic [1:0] c;
      c = encode(1'b0);
      if (k == 0) c = 2'b01;
      send(c);
      check_out(k, "R6 start state");
    end

    // R1: reset in the middle of a stream restarts the delay
    for (int k = 0; k < 40; k++) msg[k] = 1'(k % 5 == 1);
    run(10, 0, 1'b0, "R1 partial");
    run(40, 0, 1'b0, "R1 restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule